// File: doc/BRIEF.md
# Framed SPI Slave Packet Port with Ready Handshake

This block is the device side of a full-duplex serial link to a host microcontroller. Every exchange is one fixed 32-bit packet: an 8-bit identifier in the top byte above a 24-bit information field. The host drives the select, clock and data-in lines. The block drives a data-out line with an output enable, plus an active-low go signal. The go signal tells the host that the outgoing packet is loaded and clocking may start. All host lines are resynchronised into the local system clock, so the host clock must be slow next to the system clock. About eight system clocks per SCK half period is enough.

On the local side, a valid/pop queue interface supplies outgoing packets. A packet that is popped but whose transfer is cut short is held in a one-entry staging slot. It is sent on the next transfer, ahead of anything still in the queue. When nothing is staged or queued, the block builds a status packet from a fixed identifier parameter and a 24-bit local status input. It does this only when the local enable is set. Otherwise it returns all zeros. Each completed incoming packet is presented on a data bus with a one-cycle valid strobe.

Top module: `pkt_spi_slave`

## Requirements
- R1: A transfer is exactly 32 bits, with the ID in bits 31..24 and the information field in bits 23..0. After the 32nd SCK rising edge, the received word appears on `rx_data`, and `rx_valid` is high for exactly one system clock.
- R2: Bits move most significant first on both data lines. MOSI is sampled on SCK rising edges. MISO changes after SCK falling edges. Bit 31 is already on MISO when `host_go_n` falls.
- R3: `host_go_n` is high in reset and while the device is not selected. It falls some system clocks after an SS falling edge, once the outgoing packet is loaded. It returns high a few clocks after SS rises.
- R4: Each packet needs a fresh SS falling edge. If SS stays low after 32 bits, further SCK pulses produce no second `rx_valid` and no queue pop.
- R5: `spi_miso_en` is low whenever `spi_ss_n` is high, and high whenever it is low.
- R6: If a local packet is queued (`tx_valid` high), it is what the host receives. `tx_pop` is high for exactly one system clock while it is loaded.
- R7: With nothing staged or queued and `dev_enable` high, the outgoing packet is {STATUS_ID, `status_info`}. `status_info` is sampled when the packet is loaded, and later changes do not alter it.
- R8: With nothing staged or queued and `dev_enable` low, MISO carries all zeros.
- R9: If SS rises before 32 bits, no `rx_valid` is raised. A packet already popped is kept and sent on the next transfer, with no further pop, before any later queue entry.
- R10: After reset, `host_go_n` is 1, and `rx_valid` and `tx_pop` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_ss_n | input | 1 | Host select, active low |
| spi_sck | input | 1 | Host serial clock (mode 0) |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_en | output | 1 | Output enable for the MISO pad driver |
| host_go_n | output | 1 | Low when the host may start clocking |
| tx_valid | input | 1 | Local queue has a packet at its head |
| tx_data | input | 32 | Packet at the queue head |
| tx_pop | output | 1 | Removes the queue head |
| rx_valid | output | 1 | One-cycle strobe for a received packet |
| rx_data | output | 32 | Received packet |
| dev_enable | input | 1 | Allows status packets when idle |
| status_info | input | 24 | Information field of status packets |

## Verification
The bench aborts a transfer after twelve bits and then runs two full ones. A design that dropped or re-popped the staged packet would return the second queued word too early, or lose the first. It keeps SS low while sending 32 extra SCK pulses after a complete packet. A design that re-armed on bit count instead of on the select edge would strobe a second receive and pop the queue. It changes `status_info` right after the go signal falls. A design that read the status live would leak the new value into MISO. Throughout the run it also watches the output enable and the go signal against the select line on every clock, and rejects back-to-back receive strobes.

// File: rtl/pkt_spi_pkg.sv
package pkt_spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } link_st_e;
endpackage

// File: rtl/pkt_spi_sync.sv
module pkt_spi_sync #(
    parameter int         WIDTH   = 3,
    parameter int         STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] pipe_q [STAGES];
    logic [WIDTH-1:0] pipe_d [STAGES];

    always_comb begin
        pipe_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= RST_VAL;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/pkt_spi_txsel.sv
module pkt_spi_txsel #(
    parameter int               PKT_W     = 32,
    parameter int               ID_W      = 8,
    parameter logic [ID_W-1:0]  STATUS_ID = 8'hC3,
    localparam int              INFO_W    = PKT_W - ID_W
) (
    input  logic              stage_vld,
    input  logic [PKT_W-1:0]  stage_pkt,
    input  logic              q_valid,
    input  logic [PKT_W-1:0]  q_pkt,
    input  logic              enable,
    input  logic [INFO_W-1:0] status,
    output logic [PKT_W-1:0]  out_pkt,
    output logic              take_q
);
    always_comb begin
        take_q = 1'b0;
        if (stage_vld) begin
            out_pkt = stage_pkt;
        end else if (q_valid) begin
            out_pkt = q_pkt;
            take_q  = 1'b1;
        end else if (enable) begin
            out_pkt = {STATUS_ID, status};
        end else begin
            out_pkt = '0;
        end
    end
endmodule

// File: rtl/pkt_spi_core.sv
module pkt_spi_core
    import pkt_spi_pkg::*;
#(
    parameter int               PKT_W     = 32,
    parameter int               ID_W      = 8,
    parameter logic [ID_W-1:0]  STATUS_ID = 8'hC3,
    localparam int              INFO_W    = PKT_W - ID_W,
    localparam int              CNT_W     = $clog2(PKT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_s,
    input  logic              sck_s,
    input  logic              mosi_s,
    input  logic              tx_valid,
    input  logic [PKT_W-1:0]  tx_data,
    input  logic              enable,
    input  logic [INFO_W-1:0] status,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [PKT_W-1:0]  rx_data,
    output logic              go_n,
    output logic              miso_bit
);
    typedef struct packed {
        link_st_e         st;
        logic             ss_p;
        logic             sck_p;
        logic [CNT_W-1:0] cnt;
        logic [PKT_W-1:0] txs;
        logic [PKT_W-1:0] rxs;
        logic [PKT_W-1:0] rxd;
        logic             rxv;
        logic [PKT_W-1:0] stg;
        logic             stg_v;
        logic             go_n;
    } core_regs_t;

    core_regs_t q, d;
    logic [PKT_W-1:0] sel_pkt;
    logic             sel_take;
    logic             ss_fall, sck_rise, sck_fall;

    pkt_spi_txsel #(
        .PKT_W(PKT_W), .ID_W(ID_W), .STATUS_ID(STATUS_ID)
    ) i_txsel (
        .stage_vld(q.stg_v),
        .stage_pkt(q.stg),
        .q_valid  (tx_valid),
        .q_pkt    (tx_data),
        .enable   (enable),
        .status   (status),
        .out_pkt  (sel_pkt),
        .take_q   (sel_take)
    );

    assign ss_fall  = q.ss_p & ~ss_s;
    assign sck_rise = ~q.sck_p & sck_s;
    assign sck_fall = q.sck_p & ~sck_s;

    always_comb begin
        d       = q;
        d.rxv   = 1'b0;
        d.ss_p  = ss_s;
        d.sck_p = sck_s;
        tx_pop  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (ss_fall) d.st = ST_LOAD;
            end
            ST_LOAD: begin
                if (ss_s) begin
                    d.st = ST_IDLE;
                end else begin
                    d.txs = sel_pkt;
                    d.cnt = '0;
                    d.st  = ST_SHIFT;
                    if (sel_take) begin
                        tx_pop  = 1'b1;
                        d.stg   = tx_data;
                        d.stg_v = 1'b1;
                    end
                end
            end
            ST_SHIFT: begin
                if (ss_s) begin
                    d.st = ST_IDLE;
                end else begin
                    if (sck_rise) begin
                        d.rxs = {q.rxs[PKT_W-2:0], mosi_s};
                        if (q.cnt == CNT_W'(PKT_W-1)) begin
                            d.rxd   = {q.rxs[PKT_W-2:0], mosi_s};
                            d.rxv   = 1'b1;
                            d.stg_v = 1'b0;
                            d.st    = ST_HOLD;
                        end else begin
                            d.cnt = q.cnt + 1'b1;
                        end
                    end
                    if (sck_fall) d.txs = {q.txs[PKT_W-2:0], 1'b0};
                end
            end
            ST_HOLD: begin
                if (ss_s) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (d.st == ST_IDLE) d.cnt = '0;
        d.go_n = !(d.st == ST_SHIFT || d.st == ST_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.ss_p  <= 1'b1;
            q.go_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rx_valid = q.rxv;
    assign rx_data  = q.rxd;
    assign go_n     = q.go_n;
    assign miso_bit = (q.st == ST_SHIFT) ? q.txs[PKT_W-1] : 1'b0;

    // R3
    ss_hi_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |=> go_n);

    // R1
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R1
    rx_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !go_n);

    // R6
    pop_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |=> !go_n);

    // R9
    abort_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SHIFT && ss_s && q.stg_v) |=> (q.stg_v && $stable(q.stg)));
endmodule

// File: rtl/pkt_spi_slave.sv
module pkt_spi_slave #(
    parameter int               PKT_W     = 32,
    parameter int               ID_W      = 8,
    parameter logic [ID_W-1:0]  STATUS_ID = 8'hC3,
    parameter int               SYNC_N    = 2,
    localparam int              INFO_W    = PKT_W - ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_ss_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_en,
    output logic              host_go_n,
    input  logic              tx_valid,
    input  logic [PKT_W-1:0]  tx_data,
    output logic              tx_pop,
    output logic              rx_valid,
    output logic [PKT_W-1:0]  rx_data,
    input  logic              dev_enable,
    input  logic [INFO_W-1:0] status_info
);
    logic [2:0] pins_s;

    pkt_spi_sync #(
        .WIDTH(3), .STAGES(SYNC_N), .RST_VAL(3'b100)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i({spi_ss_n, spi_sck, spi_mosi}),
        .sync_o (pins_s)
    );

    pkt_spi_core #(
        .PKT_W(PKT_W), .ID_W(ID_W), .STATUS_ID(STATUS_ID)
    ) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_s     (pins_s[2]),
        .sck_s    (pins_s[1]),
        .mosi_s   (pins_s[0]),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .enable   (dev_enable),
        .status   (status_info),
        .tx_pop   (tx_pop),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .go_n     (host_go_n),
        .miso_bit (spi_miso)
    );

    assign spi_miso_en = ~spi_ss_n;
endmodule

// File: tb/test_pkt_spi_slave.sv
module test_pkt_spi_slave;
    localparam int HALF = 6;
    localparam logic [7:0] SID = 8'hC3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ss_n = 1'b1, sck = 1'b0, mosi = 1'b0;
    logic        miso, miso_en, go_n, tx_pop, rx_valid;
    logic [31:0] rx_data;
    logic        en = 1'b0;
    logic [23:0] st_info = 24'h000000;
    logic [31:0] qm [$];
    logic        tx_valid;
    logic [31:0] tx_data;

    int n_chk = 0, n_fail = 0, rx_cnt = 0, idle_run = 0;
    logic [31:0] last_rx = '0;
    logic        hv = 1'b0;
    logic [31:0] hw = '0;
    bit          pop_armed = 1'b0, prev_rxv = 1'b0, done = 1'b0;

    always #4 clk = ~clk;

    assign tx_valid = qm.size() > 0;
    assign tx_data  = (qm.size() > 0) ? qm[0] : 32'h0;

    pkt_spi_slave i_pkt_spi_slave (
        .clk(clk), .rst_n(rst_n), .spi_ss_n(ss_n), .spi_sck(sck), .spi_mosi(mosi),
        .spi_miso(miso), .spi_miso_en(miso_en), .host_go_n(go_n),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .dev_enable(en), .status_info(st_info)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // queue side and per-clock reference checks, all away from the active edge
    always @(negedge clk) begin
        if (pop_armed) begin
            void'(qm.pop_front());
            pop_armed = 1'b0;
        end
        if (tx_pop) pop_armed = 1'b1;
        if (rst_n) begin
            chk(miso_en == !ss_n, "R5", {31'b0, miso_en}, {31'b0, !ss_n});
            idle_run = ss_n ? idle_run + 1 : 0;
            if (idle_run >= 5) chk(go_n == 1'b1, "R3", {31'b0, go_n}, 32'd1);
            if (rx_valid) begin
                chk(!prev_rxv, "R1", 32'd1, 32'd0);
                rx_cnt++;
                last_rx = rx_data;
            end
            prev_rxv = rx_valid;
        end
    end

    task automatic xfer(input logic [31:0] w, input int nbits, input int extra,
                        input logic [23:0] st_after, output logic [31:0] got);
        got = '0;
        @(negedge clk) ss_n = 1'b0;
        for (int i = 0; i < 60 && go_n; i++) @(negedge clk);
        chk(go_n == 1'b0, "R3", {31'b0, go_n}, 32'd0);
        st_info = st_after;
        for (int k = 0; k < nbits + extra; k++) begin
            mosi = (k < 32) ? w[31-k] : 1'b1;
            repeat (HALF) @(negedge clk);
            if (k < 32) got = {got[30:0], miso};
            sck = 1'b1;
            repeat (HALF) @(negedge clk);
            sck = 1'b0;
        end
        repeat (8) @(negedge clk);
        ss_n = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // full packet with behavioural expectation
    task automatic packet(input logic [31:0] w, input int nbits, input int extra,
                          input logic [23:0] st_after, input string req);
        logic [31:0] exp, got;
        bit          from_q;
        int          rx0, qs0, exp_qs;
        from_q = hv || (qm.size() > 0);
        exp    = hv ? hw : (qm.size() > 0) ? qm[0] : en ? {SID, st_info} : 32'h0;
        rx0    = rx_cnt;
        qs0    = qm.size();
        exp_qs = (!hv && qs0 > 0) ? qs0 - 1 : qs0;
        xfer(w, nbits, extra, st_after, got);
        if (nbits == 32) begin
            chk(got == exp, req, got, exp);
            chk(rx_cnt == rx0 + 1, "R1", rx_cnt, rx0 + 1);
            chk(last_rx == w, "R2", last_rx, w);
            hv = 1'b0;
        end else begin
            chk(got == (exp >> (32 - nbits)), "R9", got, exp >> (32 - nbits));
            chk(rx_cnt == rx0, "R9", rx_cnt, rx0);
            if (from_q) begin hv = 1'b1; hw = exp; end
        end
        chk(qm.size() == exp_qs, (nbits == 32) ? "R6" : "R9", qm.size(), exp_qs);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10
        chk(go_n == 1'b1 && rx_valid == 1'b0 && tx_pop == 1'b0, "R10",
            {29'b0, go_n, rx_valid, tx_pop}, 32'd4);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R8: disabled, empty queue -> zeros; R1/R2 receive path
        packet(32'hA55A_0F1E, 32, 0, 24'h000000, "R8");
        // R7: status packet, field sampled at load
        en = 1'b1; st_info = 24'h12_3456;
        packet(32'h8001_0203, 32, 0, 24'hFF_EEDD, "R7");
        st_info = 24'h00_BEEF;
        packet(32'h7FFF_FFFE, 32, 0, 24'h00_BEEF, "R7");
        // R6: queued packets win over status, in order
        qm.push_back(32'h1122_3344);
        qm.push_back(32'h5566_7788);
        packet(32'h0000_0001, 32, 0, 24'h00_BEEF, "R6");
        packet(32'hFFFF_FFFF, 32, 0, 24'h00_BEEF, "R6");
        packet(32'h0F0F_0F0F, 32, 0, 24'h00_BEEF, "R7");
        // R4: SS held low with 32 extra SCK pulses gives one packet only
        qm.push_back(32'hC0DE_0001);
        qm.push_back(32'hC0DE_0002);
        packet(32'h2468_ACE0, 32, 32, 24'h00_BEEF, "R4");
        chk(qm.size() == 1, "R4", qm.size(), 1);
        packet(32'h1357_9BDF, 32, 0, 24'h00_BEEF, "R6");
        // R9: abort after 12 bits, staged packet resent without a pop
        qm.push_back(32'hDEAD_BEEF);
        qm.push_back(32'hFACE_CAFE);
        packet(32'h9999_9999, 12, 0, 24'h00_BEEF, "R9");
        packet(32'h3C3C_3C3C, 32, 0, 24'h00_BEEF, "R9");
        packet(32'hC3C3_C3C3, 32, 0, 24'h00_BEEF, "R6");
        // R9: abort of a status packet leaves nothing staged
        packet(32'h5A5A_5A5A, 7, 0, 24'h00_BEEF, "R9");
        en = 1'b0;
        packet(32'h0000_8000, 32, 0, 24'h00_BEEF, "R8");
        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule